// File: doc/BRIEF.md
# Programmable Three-Input Logic Cell

This block is a configurable logic cell with three fixed inputs (A, B, C) and three fixed outputs. A 16-bit configuration word, applied in parallel, sets up the cell. It chooses the polarity of each input and, for each of two identical function generators, which inputs take part and which three-input function is formed. A further bit switches the cell into a flip-flop mode, in which the two generated outputs carry the state and its complement.

One polarity choice per input is shared by every use of that input. A variable therefore reaches both function generators either true or complemented, never true on one and complemented on the other. Each generator has its own three-bit inhibit mask, which drops inputs that its function does not use. The third output repeats input A after its polarity choice. All outputs are registered on the cell clock, and one function code keeps the previous output value.

Top module: `hexcell`

## Requirements
- R1: Configuration bits 0, 1 and 2 complement inputs A, B and C respectively when set. The adjusted inputs feed both function generators, the flip-flop and the third output.
- R2: Function codes 0, 1 and 2 produce the AND, OR and XOR of the enabled adjusted inputs. The first generator (output D) takes its code from bits 8:6 and the second (output E) from bits 14:12.
- R3: The inhibit mask for D is bits 5:3 and the mask for E is bits 11:9, with bit order A, B, C from low to high and 1 meaning inhibited. For codes 0 to 2 an inhibited input is replaced by the identity value of the operation: 1 for AND, 0 for OR and XOR. With all three inputs inhibited, AND gives 1 and OR or XOR gives 0.
- R4: With x, y, z the masked A, B, C and an inhibited input forced to 0, the remaining codes are as follows. Code 3 is xyz + x'y'z'. Code 4 is (x+y)z. Code 5 is x(y^z) + x'y'z'. Code 6 is x'(y^z) + xy'z'.
- R5: Code 7 makes that generator's output keep its previous value.
- R6: A new output value appears at the first rising clock edge after the inputs are applied. An active-low asynchronous reset clears D, E and the third output to 0 while flip-flop mode is off, and clears the flip-flop state.
- R7: The third output F equals adjusted A, registered.
- R8: When bit 15 is set, D shows the flip-flop state and E shows its complement. The state changes only on a rising edge of adjusted B, detected as a 0 in the previous clock sample followed by a 1 in the current one. On such an edge, adjusted A sets the state.
- R9: On a trigger edge where adjusted A (set) and adjusted C (reset) are both 1, the state is cleared. On an edge where both are 0, the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | 16 | Configuration word |
| a_in | input | 1 | Input A (flip-flop set) |
| b_in | input | 1 | Input B (flip-flop trigger) |
| c_in | input | 1 | Input C (flip-flop reset) |
| d_out | output | 1 | First function output or flip-flop state |
| e_out | output | 1 | Second function output or complemented state |
| f_out | output | 1 | Registered adjusted input A |

## Verification
The hardest situation to reach is a trigger edge that occurs only because of polarity. Raw B falls while its complement bit is set, so adjusted B rises even though the pin goes low. The flip-flop sequence holds B high, sets the B polarity bit so that adjusted B drops without an edge, and then lowers raw B with reset active to produce the edge. A second hard case is a trigger held high across several clocks with set and reset changing, which must leave the state alone. The flip-flop table walks through held, falling and simultaneous set-and-reset patterns in order.

// File: rtl/hexcell_pkg.sv
package hexcell_pkg;

   localparam int CELL_INPUTS = 3;
   localparam int FSEL_W      = 3;

   typedef enum logic [FSEL_W-1:0] {
      FN_AND   = 3'd0,
      FN_OR    = 3'd1,
      FN_XOR   = 3'd2,
      FN_EQ3   = 3'd3,
      FN_ORAND = 3'd4,
      FN_XMIX  = 3'd5,
      FN_XMIXN = 3'd6,
      FN_HOLD  = 3'd7
   } fn_e;

   typedef struct packed {
      logic                   ff_mode;
      logic [FSEL_W-1:0]      sel_e;
      logic [CELL_INPUTS-1:0] msk_e;
      logic [FSEL_W-1:0]      sel_d;
      logic [CELL_INPUTS-1:0] msk_d;
      logic [CELL_INPUTS-1:0] pol;
   } cell_cfg_t;

endpackage

// File: rtl/hexcell_polarity.sv
module hexcell_polarity #(
   parameter int N_IN = 3
) (
   input  logic [N_IN-1:0] raw,
   input  logic [N_IN-1:0] pol,
   output logic [N_IN-1:0] adj
);
   for (genvar i = 0; i < N_IN; i++) begin : g_pol
      assign adj[i] = raw[i] ^ pol[i];
   end
endmodule

// File: rtl/hexcell_fgen.sv
module hexcell_fgen
   import hexcell_pkg::*;
#(
   parameter int N_IN  = 3,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IN-1:0]  x,
   input  logic [N_IN-1:0]  mask,
   input  logic [SEL_W-1:0] sel,
   output logic             y
);
   logic [N_IN-1:0] v_one;
   logic [N_IN-1:0] v_zero;
   logic            nxt;
   fn_e             code;

   for (genvar i = 0; i < N_IN; i++) begin : g_msk
      assign v_one[i]  = x[i] | mask[i];
      assign v_zero[i] = x[i] & ~mask[i];
   end

   assign code = fn_e'(sel);

   always_comb begin
      case (code)
         FN_AND:   nxt = &v_one;
         FN_OR:    nxt = |v_zero;
         FN_XOR:   nxt = ^v_zero;
         FN_EQ3:   nxt = (&v_zero) | ~(|v_zero);
         FN_ORAND: nxt = (v_zero[0] | v_zero[1]) & v_zero[2];
         FN_XMIX:  nxt = (v_zero[0] & (v_zero[1] ^ v_zero[2])) | ~(|v_zero);
         FN_XMIXN: nxt = (~v_zero[0] & (v_zero[1] ^ v_zero[2]))
                       | (v_zero[0] & ~v_zero[1] & ~v_zero[2]);
         default:  nxt = y;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y <= 1'b0;
      else        y <= nxt;
   end
endmodule

// File: rtl/hexcell_srff.sv
module hexcell_srff #(
   parameter bit RESET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic trig,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   logic trig_prev;
   logic trig_rise;
   logic nxt;

   assign trig_rise = trig & ~trig_prev;

   if (RESET_WINS) begin : g_clr_first
      always_comb nxt = clr_i ? 1'b0 : (set_i ? 1'b1 : q);
   end else begin : g_set_first
      always_comb nxt = set_i ? 1'b1 : (clr_i ? 1'b0 : q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_prev <= 1'b0;
         q         <= 1'b0;
      end else begin
         trig_prev <= trig;
         if (en && trig_rise) q <= nxt;
      end
   end
endmodule

// File: rtl/hexcell.sv
module hexcell
   import hexcell_pkg::*;
#(
   parameter int N_IN       = 3,
   parameter bit RESET_WINS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [5*N_IN:0] cfg,
   input  logic            a_in,
   input  logic            b_in,
   input  logic            c_in,
   output logic            d_out,
   output logic            e_out,
   output logic            f_out
);
   localparam int CFG_W = 5 * N_IN + 1;

   if (N_IN != CELL_INPUTS) begin : g_bad_width
      $error("hexcell: N_IN must equal %0d", CELL_INPUTS);
   end
   if (CFG_W != $bits(cell_cfg_t)) begin : g_bad_cfg
      $error("hexcell: configuration width mismatch");
   end

   cell_cfg_t       cs;
   logic [N_IN-1:0] raw;
   logic [N_IN-1:0] adj;
   logic            d_fn;
   logic            e_fn;
   logic            ff_q;
   logic            f_q;

   assign cs  = cell_cfg_t'(cfg);
   assign raw = {c_in, b_in, a_in};

   hexcell_polarity #(.N_IN(N_IN)) u_pol (
      .raw (raw),
      .pol (cs.pol),
      .adj (adj)
   );

   hexcell_fgen #(.N_IN(N_IN), .SEL_W(FSEL_W)) u_fgen_d (
      .clk   (clk),
      .rst_n (rst_n),
      .x     (adj),
      .mask  (cs.msk_d),
      .sel   (cs.sel_d),
      .y     (d_fn)
   );

   hexcell_fgen #(.N_IN(N_IN), .SEL_W(FSEL_W)) u_fgen_e (
      .clk   (clk),
      .rst_n (rst_n),
      .x     (adj),
      .mask  (cs.msk_e),
      .sel   (cs.sel_e),
      .y     (e_fn)
   );

   hexcell_srff #(.RESET_WINS(RESET_WINS)) u_ff (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cs.ff_mode),
      .trig  (adj[1]),
      .set_i (adj[0]),
      .clr_i (adj[2]),
      .q     (ff_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= adj[0];
   end

   assign d_out = cs.ff_mode ? ff_q  : d_fn;
   assign e_out = cs.ff_mode ? ~ff_q : e_fn;
   assign f_out = f_q;
endmodule

// File: rtl/hexcell_chk.sv
module hexcell_chk #(
   parameter int CFG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CFG_W-1:0] cfg,
   input logic             a_in,
   input logic             b_in,
   input logic             c_in,
   input logic             d_out,
   input logic             e_out,
   input logic             f_out
);
   logic past_valid;
   logic b_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_valid <= 1'b0;
         b_seen     <= 1'b0;
      end else begin
         past_valid <= 1'b1;
         b_seen     <= b_in ^ cfg[1];
      end
   end

   // R7: third output follows adjusted A one clock later
   a_r7_third_out: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid |-> (f_out == $past(a_in ^ cfg[0])));

   // R8: state and complement on D and E in flip-flop mode
   a_r8_ff_compl: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[15] |-> (e_out != d_out));

   // R5: hold code keeps D
   a_r5_hold_d: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && !cfg[15] && $past(!cfg[15] && cfg[8:6] == 3'd7))
      |-> $stable(d_out));

   // R9: reset wins on a trigger edge
   a_r9_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && cfg[15] &&
       $past(cfg[15] && (b_in ^ cfg[1]) && !b_seen && (a_in ^ cfg[0]) && (c_in ^ cfg[2])))
      |-> !d_out);

   // R3: AND with every input inhibited yields 1
   a_r3_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && !cfg[15] && $past(!cfg[15] && cfg[8:6] == 3'd0 && cfg[5:3] == 3'b111))
      |-> d_out);
endmodule

bind hexcell hexcell_chk #(.CFG_W(CFG_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cfg   (cfg),
   .a_in  (a_in),
   .b_in  (b_in),
   .c_in  (c_in),
   .d_out (d_out),
   .e_out (e_out),
   .f_out (f_out)
);

// File: tb/hexcell_test.sv
`timescale 1ns/1ps
module hexcell_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg = '0;
   logic        a_in = 1'b0, b_in = 1'b0, c_in = 1'b0;
   logic        d_out, e_out, f_out;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   hexcell uut (
      .clk(clk), .rst_n(rst_n), .cfg(cfg),
      .a_in(a_in), .b_in(b_in), .c_in(c_in),
      .d_out(d_out), .e_out(e_out), .f_out(f_out)
   );

   // {pol, msk_d, sel_d, msk_e, sel_e, ff, a, b, c, exp_d, exp_e, exp_f}
   localparam int NV = 17;
   localparam logic [21:0] VEC [NV] = '{
      {3'b000,3'b000,3'd0,3'b000,3'd1,1'b0,3'b111,3'b111},
      {3'b000,3'b000,3'd0,3'b000,3'd1,1'b0,3'b101,3'b011},
      {3'b000,3'b000,3'd0,3'b000,3'd1,1'b0,3'b000,3'b000},
      {3'b111,3'b000,3'd0,3'b000,3'd1,1'b0,3'b000,3'b111},
      {3'b000,3'b000,3'd2,3'b001,3'd2,1'b0,3'b110,3'b011},
      {3'b000,3'b000,3'd3,3'b000,3'd4,1'b0,3'b000,3'b100},
      {3'b000,3'b000,3'd3,3'b000,3'd4,1'b0,3'b111,3'b111},
      {3'b000,3'b000,3'd3,3'b000,3'd4,1'b0,3'b011,3'b010},
      {3'b000,3'b000,3'd5,3'b000,3'd6,1'b0,3'b110,3'b101},
      {3'b000,3'b000,3'd5,3'b000,3'd6,1'b0,3'b000,3'b100},
      {3'b000,3'b000,3'd5,3'b000,3'd6,1'b0,3'b100,3'b011},
      {3'b000,3'b000,3'd5,3'b000,3'd6,1'b0,3'b011,3'b000},
      {3'b000,3'b111,3'd0,3'b111,3'd1,1'b0,3'b000,3'b100},
      {3'b000,3'b111,3'd1,3'b111,3'd2,1'b0,3'b111,3'b001},
      {3'b000,3'b001,3'd3,3'b000,3'd3,1'b0,3'b100,3'b101},
      {3'b010,3'b000,3'd0,3'b000,3'd2,1'b0,3'b101,3'b111},
      {3'b101,3'b000,3'd1,3'b000,3'd0,1'b0,3'b101,3'b000}
   };

   // flip-flop sequence, same layout
   localparam int NF = 13;
   localparam logic [21:0] FFV [NF] = '{
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b001,3'b010},
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b011,3'b010},
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b100,3'b011},
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b110,3'b101},
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b011,3'b100},
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b000,3'b100},
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b111,3'b011},
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b100,3'b011},
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b110,3'b101},
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b000,3'b100},
      {3'b000,3'b000,3'd0,3'b000,3'd0,1'b1,3'b010,3'b100},
      {3'b010,3'b000,3'd0,3'b000,3'd0,1'b1,3'b011,3'b100},
      {3'b010,3'b000,3'd0,3'b000,3'd0,1'b1,3'b001,3'b010}
   };

   function automatic string vtag(int i);
      if (i <= 2)       return "R2";
      else if (i == 3)  return "R1";
      else if (i == 4)  return "R3";
      else if (i <= 11) return "R4";
      else if (i <= 13) return "R3";
      else if (i == 14) return "R4";
      else              return "R1";
   endfunction

   function automatic string ftag(int i);
      if (i == 1 || i == 6 || i == 10) return "R9";
      else if (i >= 11)                return "R1";
      else                             return "R8";
   endfunction

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic apply(input logic [21:0] v);
      cfg  = {v[6], v[9:7], v[12:10], v[15:13], v[18:16], v[21:19]};
      a_in = v[5]; b_in = v[4]; c_in = v[3];
   endtask

   task automatic run_vec(input logic [21:0] v, input string tag);
      apply(v);
      @(posedge clk);
      @(negedge clk);
      check(tag, "d_out", d_out, v[2]);
      check(tag, "e_out", e_out, v[1]);
      check("R7", "f_out", f_out, v[0]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R6: reset state
      repeat (3) @(negedge clk);
      check("R6", "reset d_out", d_out, 1'b0);
      check("R6", "reset e_out", e_out, 1'b0);
      check("R6", "reset f_out", f_out, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) run_vec(VEC[i], vtag(i));

      // R5: hold on both generators, then on D only
      run_vec({3'b000,3'b000,3'd1,3'b000,3'd1,1'b0,3'b111,3'b111}, "R5");
      run_vec({3'b000,3'b000,3'd7,3'b000,3'd7,1'b0,3'b000,3'b110}, "R5");
      run_vec({3'b000,3'b000,3'd7,3'b000,3'd1,1'b0,3'b000,3'b100}, "R5");

      // R6: output changes only at the clock edge
      apply({3'b000,3'b000,3'd1,3'b000,3'd1,1'b0,3'b111,3'b111});
      #2;
      check("R6", "d_out before edge", d_out, 1'b1);
      check("R6", "e_out before edge", e_out, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check("R6", "e_out after edge", e_out, 1'b1);

      // R6: asynchronous reset mid-run
      rst_n = 1'b0;
      #2;
      check("R6", "async d_out", d_out, 1'b0);
      check("R6", "async e_out", e_out, 1'b0);
      check("R6", "async f_out", f_out, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NF; i++) run_vec(FFV[i], ftag(i));

      finish_run();
   end
endmodule